// File: doc/BRIEF.md
# Exhaustive Adder Sweep Self-Test

This block tests a ripple-carry adder on chip against every possible operand pair. After a start pulse, a free-running sweep counter presents one pair per clock to an adder built from a chain of full-adder cells. The adder's full-width result, including its carry-out, is registered together with the operands that produced it. In the next cycle a checker removes both operands from that result by subtraction. A remainder other than zero is a miss.

Any miss sets an error flag that stays set for the rest of the sweep. The operand pair of the first miss is held for later reading. When the last pair has been checked, done rises and the counter halts until the next start. A fault-mask input flips chosen result bits before they are registered, so the checking path can be shown to catch a defect. The operand width is a parameter, so a narrow copy sweeps its whole space in a few hundred cycles.

Top module: `adder_sweep_bist`

## Requirements
- R1: After synchronous reset, `done`, `error`, `fail_a` and `fail_b` are all zero, and an ongoing sweep is abandoned.
- R2: The clock edge that samples `start` high while idle begins a sweep of all 2^(2*OP_W) pairs, one per clock. `done` first reads high after exactly 2^(2*OP_W)+1 further rising edges.
- R3: With an all-zero fault mask, `error` is still 0 at the end of a full sweep.
- R4: Bit i of `fault_mask` inverts bit i of the (OP_W+1)-bit adder result, where bit OP_W is the carry-out, in the cycle when the pair is applied. Any nonzero mask in the cycle of pair k makes `error` read 1 at the end of the sweep.
- R5: Pair k uses A = k mod 2^OP_W (the low half of the counter) and B = k div 2^OP_W (the high half). On the first miss, `fail_a` and `fail_b` capture that A and B.
- R6: Later misses in the same sweep leave `fail_a`, `fail_b` and `error` unchanged.
- R7: `error` stays set until the next accepted start. That start clears `error`, `done`, `fail_a` and `fail_b` at the same edge.
- R8: A `start` pulse during a sweep is ignored, and the sweep ends on its original schedule.
- R9: After the sweep ends, `done` stays high and no more pairs are checked: a nonzero `fault_mask` while idle does not change `error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Starts a sweep when idle |
| fault_mask | input | OP_W+1 | Bits XORed into the adder result (MSB = carry-out) |
| done | output | 1 | Sweep finished, held until the next start |
| error | output | 1 | Sticky: some pair produced a wrong result |
| fail_a | output | OP_W | Operand A of the first failing pair |
| fail_b | output | OP_W | Operand B of the first failing pair |

## Verification
The hardest case to reach from the ports is a defect confined to a single chosen pair, deep in the sweep, followed later by a second defect. The bench counts clocks from the start edge and raises `fault_mask` only in the cycle that pair k is applied. It then checks that the captured pair equals k split into its two halves, and that the later injection leaves it alone. The same cycle count checks when done arrives, with and without a stray start in mid-sweep.

// File: rtl/adder_bist_pkg.sv
package adder_bist_pkg;
  localparam int unsigned BIST_OP_W_DEFAULT = 16;

  function automatic int unsigned bist_cnt_width(input int unsigned op_w);
    return 2 * op_w;
  endfunction
endpackage

// File: rtl/bist_fa_cell.sv
module bist_fa_cell (
  input  logic x,
  input  logic y,
  input  logic cin,
  output logic s,
  output logic cout
);
  logic p;
  assign p    = x ^ y;
  assign s    = p ^ cin;
  assign cout = (x & y) | (cin & p);
endmodule

// File: rtl/bist_ripple_adder.sv
module bist_ripple_adder #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W:0]   res
);
  logic [W:0] carry;
  assign carry[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_cell
    bist_fa_cell u_fa (
      .x    (a[i]),
      .y    (b[i]),
      .cin  (carry[i]),
      .s    (res[i]),
      .cout (carry[i+1])
    );
  end

  assign res[W] = carry[W];
endmodule

// File: rtl/bist_result_check.sv
module bist_result_check #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         vld,
  input  logic         last,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W:0]   res,
  output logic         done,
  output logic         err,
  output logic [W-1:0] fail_a,
  output logic [W-1:0] fail_b
);
  localparam int unsigned RW = W + 1;

  logic [RW-1:0] remain;
  logic          miss;

  assign remain = res - RW'(op_a) - RW'(op_b);
  assign miss   = vld && (remain != '0);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      done   <= 1'b0;
      err    <= 1'b0;
      fail_a <= '0;
      fail_b <= '0;
    end else begin
      if (vld && last) done <= 1'b1;
      if (miss && !err) begin
        err    <= 1'b1;
        fail_a <= op_a;
        fail_b <= op_b;
      end
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!done && !err)); // R1
  AST_FIRST_MISS: assert property (@(posedge clk) disable iff (rst)
    (miss && !err && !clr) |=> err); // R4
  AST_FAIL_HELD: assert property (@(posedge clk) disable iff (rst)
    (err && !clr) |=> ($stable(fail_a) && $stable(fail_b))); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err && !clr) |=> err); // R7
endmodule

// File: rtl/adder_sweep_bist.sv
module adder_sweep_bist
  import adder_bist_pkg::*;
#(
  parameter int unsigned OP_W = BIST_OP_W_DEFAULT
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [OP_W:0]   fault_mask,
  output logic            done,
  output logic            error,
  output logic [OP_W-1:0] fail_a,
  output logic [OP_W-1:0] fail_b
);
  localparam int unsigned CNT_W = bist_cnt_width(OP_W);

  logic [CNT_W-1:0] cnt;
  logic             running;
  logic             cnt_last;
  logic             accept;
  logic [OP_W:0]    sum_raw;
  logic [OP_W:0]    sum_fault;

  logic [OP_W-1:0]  p_a, p_b;
  logic [OP_W:0]    p_res;
  logic             p_vld, p_last;

  assign cnt_last = (cnt == {CNT_W{1'b1}});
  assign accept   = start && !running;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (accept) begin
      cnt     <= '0;
      running <= 1'b1;
    end else if (running) begin
      cnt <= cnt + CNT_W'(1);
      if (cnt_last) running <= 1'b0;
    end
  end

  bist_ripple_adder #(.W(OP_W)) u_add (
    .a   (cnt[OP_W-1:0]),
    .b   (cnt[CNT_W-1:OP_W]),
    .cin (1'b0),
    .res (sum_raw)
  );

  assign sum_fault = sum_raw ^ fault_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_a    <= '0;
      p_b    <= '0;
      p_res  <= '0;
      p_vld  <= 1'b0;
      p_last <= 1'b0;
    end else begin
      p_a    <= cnt[OP_W-1:0];
      p_b    <= cnt[CNT_W-1:OP_W];
      p_res  <= sum_fault;
      p_vld  <= running && !accept;
      p_last <= running && cnt_last;
    end
  end

  bist_result_check #(.W(OP_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .clr    (accept),
    .vld    (p_vld),
    .last   (p_last),
    .op_a   (p_a),
    .op_b   (p_b),
    .res    (p_res),
    .done   (done),
    .err    (error),
    .fail_a (fail_a),
    .fail_b (fail_b)
  );

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (running && !cnt_last) |=> (cnt == $past(cnt) + CNT_W'(1))); // R2
  AST_RUN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (running && !cnt_last) |=> running); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !running); // R9
endmodule

// File: tb/adder_sweep_bist_tb_top.sv
module adder_sweep_bist_tb_top;
  localparam int W     = 4;
  localparam int NPAIR = 1 << (2 * W);
  localparam int NV    = 6;

  localparam int         VK1 [NV] = '{-1, 0,      37,     255,    100,    17};
  localparam logic [W:0] VM1 [NV] = '{5'h00, 5'h01, 5'h10, 5'h08, 5'h01, 5'h1f};
  localparam int         VK2 [NV] = '{-1, -1,     -1,     -1,     200,    -1};
  localparam logic [W:0] VM2 [NV] = '{5'h00, 5'h00, 5'h00, 5'h00, 5'h02, 5'h00};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W:0]   fault_mask = '0;
  logic         done, error;
  logic [W-1:0] fail_a, fail_b;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit ended = 1'b0;

  always #5 clk = ~clk;

  adder_sweep_bist #(.OP_W(W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .fault_mask(fault_mask),
    .done(done), .error(error), .fail_a(fail_a), .fail_b(fail_b)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      finish_run();
    end
  end

  task automatic sweep(input int k1, input logic [W:0] m1, input int k2,
                       input logic [W:0] m2, input int rs_j, output int done_at);
    done_at = -1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int j = 0; j < NPAIR + 20; j++) begin
      if (j == rs_j) start = 1'b1; else start = 1'b0;
      fault_mask = (j == k1) ? m1 : (j == k2) ? m2 : '0;
      if (done && done_at < 0) done_at = j;
      if (done_at >= 0) break;
      @(negedge clk);
    end
    fault_mask = '0;
    start = 1'b0;
  endtask

  initial begin
    int d;
    int k;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b0 && error == 1'b0, "R1 reset flags", {done, error}, 0);
    chk(fail_a == 0 && fail_b == 0, "R1 reset capture", {fail_b, fail_a}, 0);

    for (int v = 0; v < NV; v++) begin
      sweep(VK1[v], VM1[v], VK2[v], VM2[v], -1, d);
      chk(d == NPAIR + 1, "R2 done timing", d, NPAIR + 1);
      if (VK1[v] < 0) begin
        chk(error == 1'b0, "R3 clean sweep", error, 0);
      end else begin
        k = VK1[v];
        chk(error == 1'b1, "R4 injected miss", error, 1);
        chk(int'(fail_a) == k % (1 << W), "R5 fail_a", fail_a, k % (1 << W));
        chk(int'(fail_b) == k / (1 << W), "R5 fail_b", fail_b, k / (1 << W));
        if (VK2[v] >= 0)
          chk(int'(fail_a) == k % (1 << W) && int'(fail_b) == k / (1 << W),
              "R6 first kept", {fail_b, fail_a}, k);
      end
      // R9: idle mask must not be checked
      fault_mask = 5'h1f;
      repeat (3) @(negedge clk);
      fault_mask = '0;
      chk(done == 1'b1, "R9 done held", done, 1);
      chk(error == (VK1[v] >= 0), "R9 idle mask ignored", error, VK1[v] >= 0);
    end

    // R7: error held, then cleared by the next start
    sweep(10, 5'h04, -1, 5'h00, -1, d);
    repeat (5) @(negedge clk);
    chk(error == 1'b1, "R7 error sticky", error, 1);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(error == 0 && done == 0 && fail_a == 0 && fail_b == 0,
        "R7 start clears", {error, done, fail_b, fail_a}, 0);
    for (int j = 1; j < NPAIR + 20; j++) begin
      if (done) break;
      @(negedge clk);
    end
    chk(error == 1'b0, "R7 clean after clear", error, 0);

    // R8: stray start mid-sweep
    sweep(-1, 5'h00, -1, 5'h00, 50, d);
    chk(d == NPAIR + 1, "R8 start ignored", d, NPAIR + 1);

    // R1: reset mid-sweep with a captured failure
    sweep(3, 5'h01, -1, 5'h00, -1, d);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    fault_mask = 5'h01;
    repeat (5) @(negedge clk);
    fault_mask = '0;
    rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    chk(error == 0 && done == 0 && fail_a == 0 && fail_b == 0,
        "R1 mid-sweep reset", {error, done, fail_b, fail_a}, 0);
    repeat (NPAIR + 5) @(negedge clk);
    chk(done == 1'b0, "R1 sweep abandoned", done, 0);

    finish_run();
  end
endmodule